// File: doc/BRIEF.md
# Two-Player Lead Tracker

This block referees a game between two players that is played one round per clock cycle. In each cycle every player either scores one point or does not, and both may score in the same cycle. The block keeps only the running score difference of the game in progress. When a player's lead reaches the winning margin (two points by default), it raises that player's win flag in the same cycle as the deciding round. The flag lasts one cycle, and the next cycle opens a fresh game with the players level.

The win flags are a Mealy output: combinational from the present round input and the stored difference. Reset is part of the function and is not just an initialisation. In a cycle with `rst_n` low, the stored difference is read as zero, but that cycle's round still counts. The register keeps the smallest signed encoding that can hold the leads short of a win. With the default margin this is two bits. The spare code reads as a tied game.

Top module: `lead_tracker`

## Requirements
- R1: `win_o[0]` is 1 in exactly those cycles where the current game's sum of (`score_i[0]` − `score_i[1]`), counting the present cycle, reaches +2. `score_i[0]` is player 0's point for the round.
- R2: `win_o[1]` is 1 in exactly those cycles where the current game's sum of (`score_i[1]` − `score_i[0]`), counting the present cycle, reaches +2. `score_i[1]` is player 1's point for the round.
- R3: At most one bit of `win_o` is 1 in any cycle.
- R4: The cycle after any cycle with a win flag set starts a new game, with the difference back at zero.
- R5: In a cycle with `rst_n` low, the block treats the stored difference as zero. It still adds that cycle's round to the difference and can still raise a flag. With margin 2, that flag is always 00.
- R6: Rounds 00 and 11 never raise a flag and leave the difference unchanged.
- R7: A point by the trailing player reduces the leader's advantage by one. Leads can swing across a tie, from +1 to −1 and onwards, without any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one round per rising edge |
| rst_n | input | 1 | Active-low game reset; the current round is scored from a zero difference |
| score_i | input | 2 | Round points: bit 0 for player 0, bit 1 for player 1 |
| win_o | output | 2 | Win flags: bit 0 for player 0, bit 1 for player 1 |

## Verification
The bench targets four corner cases:
- A reset cycle that carries a scoring round. A design that clears the register but drops the input would miss the following win.
- The round right after a win. A design that keeps the old lead instead of restarting would flag again one point too early.
- Tied rounds (00 or 11) in the middle of a lead. A design that treats them as points, or clears the lead on them, would shift the winning cycle.
- Lead reversals through zero. These expose sign or saturation mistakes, which would make the win appear late or never.

The 16-cycle reference game and a long random stream are also compared every cycle with an integer model.

// File: rtl/lead_pkg.sv
package lead_pkg;

  // Flag codes on the win output: bit 0 player 0, bit 1 player 1
  typedef enum logic [1:0] {
    WIN_NONE = 2'b00,
    WIN_P0   = 2'b01,
    WIN_P1   = 2'b10
  } win_e;

  // Change in (player0 - player1) contributed by one round
  function automatic logic signed [1:0] round_delta(input logic [1:0] pts);
    logic signed [1:0] d;
    unique case (pts)
      2'b01:   d = 2'sb01;
      2'b10:   d = 2'sb11;
      default: d = 2'sb00;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lead_decode.sv
// Turns the stored difference into the effective one for this cycle:
// a reset cycle or an out-of-range code both read as a tie.
module lead_decode #(
  parameter int MARGIN = 2,
  parameter int SW     = $clog2(MARGIN) + 1
) (
  input  logic                 rst_n,
  input  logic signed [SW-1:0] state_q,
  output logic signed [SW-1:0] diff_eff
);

  localparam logic signed [SW-1:0] LIM = SW'(MARGIN - 1);

  logic out_of_range;

  always_comb begin
    out_of_range = (state_q > LIM) || (state_q < -LIM);
    if (!rst_n || out_of_range) diff_eff = '0;
    else                        diff_eff = state_q;
  end

endmodule

// File: rtl/lead_step.sv
// Adds the round to the effective difference, decides a win,
// and forms the difference to store for the next round.
module lead_step
  import lead_pkg::*;
#(
  parameter int MARGIN = 2,
  parameter int SW     = $clog2(MARGIN) + 1
) (
  input  logic signed [SW-1:0] diff_eff,
  input  logic [1:0]           score,
  output logic [1:0]           win,
  output logic signed [SW-1:0] state_d
);

  localparam logic signed [SW:0] POS_WIN = (SW+1)'(MARGIN);
  localparam logic signed [SW:0] NEG_WIN = -POS_WIN;

  logic signed [1:0]  delta;
  logic signed [SW:0] sum;
  win_e               flag;

  always_comb begin
    delta = round_delta(score);
    sum   = $signed({diff_eff[SW-1], diff_eff})
          + $signed({{(SW-1){delta[1]}}, delta});
    if (sum == POS_WIN)      flag = WIN_P0;
    else if (sum == NEG_WIN) flag = WIN_P1;
    else                     flag = WIN_NONE;
    win = flag;
    if (flag != WIN_NONE) state_d = '0;
    else                  state_d = sum[SW-1:0];
  end

endmodule

// File: rtl/lead_state_reg.sv
// Difference register; reset is applied upstream as a functional input.
module lead_state_reg #(
  parameter int SW = 2
) (
  input  logic                 clk,
  input  logic signed [SW-1:0] state_d,
  output logic signed [SW-1:0] state_q
);

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

endmodule

// File: rtl/lead_tracker.sv
module lead_tracker #(
  parameter int MARGIN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] score_i,
  output logic [1:0] win_o
);

  localparam int SW = $clog2(MARGIN) + 1;

  logic signed [SW-1:0] state_q;
  logic signed [SW-1:0] state_d;
  logic signed [SW-1:0] diff_eff;

  lead_decode #(.MARGIN(MARGIN), .SW(SW)) decode_i (
    .rst_n    (rst_n),
    .state_q  (state_q),
    .diff_eff (diff_eff)
  );

  lead_step #(.MARGIN(MARGIN), .SW(SW)) step_i (
    .diff_eff (diff_eff),
    .score    (score_i),
    .win      (win_o),
    .state_d  (state_d)
  );

  lead_state_reg #(.SW(SW)) reg_i (
    .clk     (clk),
    .state_d (state_d),
    .state_q (state_q)
  );

endmodule

// File: rtl/lead_tracker_chk.sv
module lead_tracker_chk #(
  parameter int SW = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           score_i,
  input logic [1:0]           win_o,
  input logic signed [SW-1:0] state_q
);

  // Checks start once a reset cycle has been seen
  logic armed_q = 1'b0;
  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b1;
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    $onehot0(win_o)); // R3

  AST_P0_WIN_ON_P0_POINT: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    win_o[0] |-> score_i == 2'b01); // R1

  AST_P1_WIN_ON_P1_POINT: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    win_o[1] |-> score_i == 2'b10); // R2

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (win_o != 2'b00) |=> (win_o == 2'b00)); // R4

  AST_RESET_ROUND_QUIET: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    !rst_n |-> (win_o == 2'b00)); // R5

  AST_TIE_ROUND_QUIET: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (score_i == 2'b00 || score_i == 2'b11) |-> (win_o == 2'b00)); // R6

  AST_TIE_ROUND_HOLDS: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (rst_n && (score_i == 2'b00 || score_i == 2'b11)) |=> state_q == $past(state_q)); // R6

endmodule

bind lead_tracker lead_tracker_chk #(.SW(SW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .score_i (score_i),
  .win_o   (win_o),
  .state_q (state_q)
);

// File: tb/lead_tracker_tb_top.sv
`timescale 1ns/1ps
module lead_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [1:0] score_i = 2'b00;
  logic [1:0] win_o;

  int checks = 0;
  int failures = 0;
  int model_d = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  lead_tracker dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .score_i (score_i),
    .win_o   (win_o)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // One round: drive at falling edge, check settled Mealy output, update model
  task automatic step(input bit rst, input logic [1:0] pts, input string req);
    logic [1:0] exp;
    @(negedge clk);
    rst_n   = ~rst;
    score_i = pts;
    #2;
    if (rst) model_d = 0;
    model_d += int'(pts[0]) - int'(pts[1]);
    if (model_d == 2)       exp = 2'b01;
    else if (model_d == -2) exp = 2'b10;
    else                    exp = 2'b00;
    if (exp != 2'b00) model_d = 0;
    check(req, win_o, exp);
  endtask

  task automatic t_reset_state;
    step(1'b1, 2'b00, "R5 reset round quiet");
    step(1'b0, 2'b00, "R6 tie after reset");
  endtask

  task automatic t_reference;
    logic [1:0] xs [16] = '{2'b01,2'b01,2'b00,2'b10,2'b11,2'b00,2'b10,2'b10,
                            2'b01,2'b01,2'b01,2'b10,2'b00,2'b01,2'b01,2'b00};
    logic [1:0] ys [16] = '{2'b00,2'b01,2'b00,2'b00,2'b00,2'b00,2'b10,2'b00,
                            2'b00,2'b00,2'b01,2'b00,2'b00,2'b00,2'b01,2'b00};
    for (int i = 0; i < 16; i++) begin
      step((i == 0) || (i == 12), xs[i], "R1 R2 reference model");
      check("R1 R2 reference table", win_o, ys[i]);
    end
  endtask

  task automatic t_p0_win;
    step(1'b1, 2'b00, "R5 setup");
    step(1'b0, 2'b01, "R1 first point");
    step(1'b0, 2'b01, "R1 player0 wins");
    check("R1 flag value", win_o, 2'b01);
  endtask

  task automatic t_p1_win;
    step(1'b1, 2'b00, "R5 setup");
    step(1'b0, 2'b10, "R2 first point");
    step(1'b0, 2'b10, "R2 player1 wins");
    check("R2 flag value", win_o, 2'b10);
  endtask

  task automatic t_restart;
    step(1'b1, 2'b01, "R5 reset round counts");
    step(1'b0, 2'b01, "R1 win");
    step(1'b0, 2'b01, "R4 no flag after restart");
    check("R4 restart quiet", win_o, 2'b00);
    step(1'b0, 2'b01, "R4 second game win");
    check("R4 second game flag", win_o, 2'b01);
  endtask

  task automatic t_tie_rounds;
    step(1'b1, 2'b10, "R5 setup lead");
    step(1'b0, 2'b11, "R6 both score");
    step(1'b0, 2'b00, "R6 neither scores");
    step(1'b0, 2'b11, "R6 both score again");
    check("R6 tie quiet", win_o, 2'b00);
    step(1'b0, 2'b10, "R6 lead kept, win");
    check("R6 lead kept", win_o, 2'b10);
  endtask

  task automatic t_reset_mid_game;
    step(1'b1, 2'b00, "R5 setup");
    step(1'b0, 2'b01, "R5 lead one");
    step(1'b1, 2'b01, "R5 reset with point");
    check("R5 reset clears lead", win_o, 2'b00);
    step(1'b0, 2'b01, "R5 reset point counted");
    check("R5 win after reset", win_o, 2'b01);
  endtask

  task automatic t_swing;
    step(1'b1, 2'b00, "R5 setup");
    step(1'b0, 2'b01, "R7 plus one");
    step(1'b0, 2'b10, "R7 back to tie");
    step(1'b0, 2'b10, "R7 minus one");
    check("R7 swing quiet", win_o, 2'b00);
    step(1'b0, 2'b01, "R7 tie again");
    step(1'b0, 2'b01, "R7 plus one again");
    step(1'b0, 2'b01, "R7 win after swing");
    check("R7 swing win", win_o, 2'b01);
  endtask

  task automatic t_random;
    for (int i = 0; i < 3000; i++) begin
      step(($urandom_range(0, 31) == 0), 2'($urandom_range(0, 3)), "R1 R2 R3 random");
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_reference();
    t_p0_win();
    t_p1_win();
    t_restart();
    t_tie_rounds();
    t_reset_mid_game();
    t_swing();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule